// File: doc/BRIEF.md
# Predication Configuration Table Decoder

This block keeps a small bank of key-value predication configuration entries and expands them into two lookup tables, one per register class (integer and floating point), each with one slot per architectural register. Each entry names a target register and a class together with the predication settings for that register. Software fills the bank one entry at a time through a write port.

Any configuration write starts a rebuild pass. The pass clears a working copy of both tables and then walks the entries one per cycle in ascending order, scattering each valid entry into its class table. At the end of the pass the working copy is committed to the live tables in a single cycle.

A combinational lookup port takes a register class and a register index and returns that register's settings from the live tables: enabled, zeroing, inversion and predicate register index. Because the live copy changes only at commit, a lookup made during a pass sees the tables as they were before the pass began.

Top module: `pred_cfg_decoder`

## Requirements
- R1: After reset `busy_o` is 0 and every lookup in both classes returns all-zero settings.
- R2: A write with `cfg_we_i` high at a rising edge makes `busy_o` high from that edge for exactly 18 cycles: one clear cycle, 16 walk cycles and one commit cycle. It is low afterwards if no further write occurs.
- R3: The class bit selects the table that an entry fills. Bit 1 of the entry equal to 0 selects the integer table and equal to 1 selects the floating-point table. The same register index in the other class stays disabled.
- R4: A configured slot returns `lu_en_o`=1 and carries the entry's fields. The entry layout is: bit 0 valid, bit 1 class, bits 6:2 target register, bit 7 zeroing, bit 8 inversion, bits 13:9 predicate register index.
- R5: An entry whose valid bit (bit 0) is 0 is skipped, so an all-zero entry does not enable integer register 0.
- R6: Entries are applied from 0 to 15. When two valid entries name the same class and register, the settings of the higher-numbered entry are returned.
- R7: Both tables are cleared at the start of every pass. A register that is no longer named by any valid entry reads as disabled after the pass.
- R8: While `busy_o` is high, lookups return the settings that were live before the pass. The new settings appear together in the cycle after `busy_o` falls.
- R9: A lookup of a register whose slot is disabled returns all-zero settings.
- R10: A write during a pass restarts the pass. `busy_o` then stays high for 18 cycles from the last write, and the committed tables reflect every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration entry write strobe |
| cfg_addr_i | input | 4 | Index of the entry being written |
| cfg_wdata_i | input | 14 | Entry value, laid out as described in R4 |
| lu_cls_i | input | 1 | Lookup class, 0 integer and 1 floating point |
| lu_reg_i | input | 5 | Lookup register index |
| lu_en_o | output | 1 | Register is predicated |
| lu_zero_o | output | 1 | Zeroing flag |
| lu_inv_o | output | 1 | Inversion flag |
| lu_pidx_o | output | 5 | Predicate register index |
| busy_o | output | 1 | Rebuild pass in progress |

## Verification
Two functions can share a cycle here. A configuration write can land while a rebuild pass is walking or committing, and a lookup can be served while the live tables are about to be replaced. The bench provokes the first by writing a second entry several cycles into a pass. It judges the result by the busy length counted from the last write and by both entries being visible afterwards. It provokes the second by looking up a register mid-pass, expecting the old settings until `busy_o` falls and the new settings in the next cycle.

// File: rtl/pred_cfg_pkg.sv
package pred_cfg_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned PIDX_W = 5;

  typedef struct packed {
    logic [PIDX_W-1:0] pidx;
    logic              inv;
    logic              zero;
    logic [REG_W-1:0]  reg_idx;
    logic              cls;
    logic              valid;
  } cfg_entry_t;

  typedef struct packed {
    logic              en;
    logic              zero;
    logic              inv;
    logic [PIDX_W-1:0] pidx;
  } slot_t;

  localparam int unsigned CFG_W = $bits(cfg_entry_t);
endpackage

// File: rtl/pred_cfg_bank.sv
module pred_cfg_bank
  import pred_cfg_pkg::*;
#(
  parameter int unsigned NUM_CFG = 16,
  localparam int unsigned IDX_W = $clog2(NUM_CFG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  cfg_entry_t       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output cfg_entry_t       rdata_o
);
  cfg_entry_t [NUM_CFG-1:0] ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else if (we_i) ent_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = ent_q[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(waddr_i)] == $past(wdata_i)); // R4
endmodule

// File: rtl/pred_rebuild_seq.sv
module pred_rebuild_seq #(
  parameter int unsigned NUM_CFG = 16,
  localparam int unsigned IDX_W = $clog2(NUM_CFG),
  localparam int unsigned PASS_LEN = NUM_CFG + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             clear_o,
  output logic             apply_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             commit_o
);
  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_WALK, S_COMMIT} state_e;
  state_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      S_IDLE:   ;
      S_CLEAR: begin
        st_d  = S_WALK;
        idx_d = '0;
      end
      S_WALK: begin
        if (idx_q == IDX_W'(NUM_CFG - 1)) st_d = S_COMMIT;
        else idx_d = idx_q + 1'b1;
      end
      S_COMMIT: st_d = S_IDLE;
      default:  st_d = S_IDLE;
    endcase
    // a write always restarts the pass, even on the commit cycle
    if (start_i) begin
      st_d  = S_CLEAR;
      idx_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign clear_o  = (st_q == S_CLEAR) && !start_i;
  assign apply_o  = (st_q == S_WALK) && !start_i;
  assign commit_o = (st_q == S_COMMIT) && !start_i;
  assign idx_o    = idx_q;

  // pass-length checker
  logic [$clog2(PASS_LEN+1)-1:0] chk_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_cnt_q <= '0;
    else if (start_i) chk_cnt_q <= '0;
    else if (busy_o) chk_cnt_q <= chk_cnt_q + 1'b1;
  end

  AST_PASS_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> chk_cnt_q == ($bits(chk_cnt_q))'(PASS_LEN - 1)); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && !apply_o); // R10
  AST_COMMIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o); // R2
endmodule

// File: rtl/pred_class_table.sv
module pred_class_table
  import pred_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter logic        CLS      = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             apply_i,
  input  cfg_entry_t       ent_i,
  input  logic             commit_i,
  input  logic [REG_W-1:0] lu_reg_i,
  output slot_t            lu_slot_o
);
  slot_t [NUM_REGS-1:0] shd_q, act_q;
  logic  [NUM_REGS-1:0] shd_en;
  logic                 hit;

  assign hit = apply_i && ent_i.valid && (ent_i.cls == CLS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shd_q <= '0;
    else if (clear_i) shd_q <= '0;
    else if (hit) shd_q[ent_i.reg_idx] <= '{en: 1'b1, zero: ent_i.zero,
                                           inv: ent_i.inv, pidx: ent_i.pidx};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (commit_i) act_q <= shd_q;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_en
    assign shd_en[g] = shd_q[g].en;
  end

  assign lu_slot_o = act_q[lu_reg_i];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> $countones(shd_en) == 0); // R7
  AST_LIVE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q)); // R8
  AST_SKIP_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !ent_i.valid) |=> $stable(shd_q)); // R5
endmodule

// File: rtl/pred_cfg_decoder.sv
module pred_cfg_decoder
  import pred_cfg_pkg::*;
#(
  parameter int unsigned NUM_CFG  = 16,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W = $clog2(NUM_CFG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              lu_cls_i,
  input  logic [REG_W-1:0]  lu_reg_i,
  output logic              lu_en_o,
  output logic              lu_zero_o,
  output logic              lu_inv_o,
  output logic [PIDX_W-1:0] lu_pidx_o,
  output logic              busy_o
);
  logic             clear, apply, commit;
  logic [IDX_W-1:0] walk_idx;
  cfg_entry_t       walk_ent;
  slot_t [1:0]      cls_slot;
  slot_t            sel;

  pred_cfg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_entry_t'(cfg_wdata_i)),
    .raddr_i (walk_idx),
    .rdata_o (walk_ent)
  );

  pred_rebuild_seq #(.NUM_CFG(NUM_CFG)) u_seq (
    .clk_i, .rst_ni,
    .start_i  (cfg_we_i),
    .busy_o   (busy_o),
    .clear_o  (clear),
    .apply_o  (apply),
    .idx_o    (walk_idx),
    .commit_o (commit)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cls
    pred_class_table #(.NUM_REGS(NUM_REGS), .CLS(1'(c))) u_tbl (
      .clk_i, .rst_ni,
      .clear_i   (clear),
      .apply_i   (apply),
      .ent_i     (walk_ent),
      .commit_i  (commit),
      .lu_reg_i  (lu_reg_i),
      .lu_slot_o (cls_slot[c])
    );
  end

  always_comb begin
    sel = cls_slot[lu_cls_i];
    if (!sel.en) sel = '0;
  end

  assign lu_en_o   = sel.en;
  assign lu_zero_o = sel.zero;
  assign lu_inv_o  = sel.inv;
  assign lu_pidx_o = sel.pidx;

  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lu_en_o |-> !lu_zero_o && !lu_inv_o && lu_pidx_o == '0); // R9
  AST_OUT_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $stable(lu_cls_i) && $stable(lu_reg_i) && !$past(commit))
      |-> $stable(lu_pidx_o)); // R8
endmodule

// File: tb/pred_cfg_decoder_tb.sv
module pred_cfg_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [13:0] wdata = '0;
  logic cls = 1'b0;
  logic [4:0] rg = '0;
  logic en, zr, iv, bsy;
  logic [4:0] pidx;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  pred_cfg_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .lu_cls_i(cls), .lu_reg_i(rg), .lu_en_o(en),
    .lu_zero_o(zr), .lu_inv_o(iv), .lu_pidx_o(pidx), .busy_o(bsy));

  function automatic logic [13:0] mk(bit v, bit c, int r, bit z, bit i, int p);
    return {5'(p), i, z, 5'(r), c, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [13:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (bsy && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  // returns {en,zero,inv,pidx}
  task automatic look(bit c, int r, output logic [7:0] s);
    cls = c; rg = 5'(r); #1;
    s = {en, zr, iv, pidx};
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 busy", 32'(bsy), 0);
    look(0, 0, s); check("R1 int0", 32'(s), 0);
    look(1, 31, s); check("R1 fp31", 32'(s), 0);
  endtask

  task automatic t_busy_len();
    int cnt = 0;
    @(negedge clk); we = 1'b1; addr = 4'd3; wdata = mk(1, 0, 7, 1, 0, 9);
    @(negedge clk); we = 1'b0;
    while (bsy && cnt < 100) begin cnt++; @(negedge clk); end
    check("R2 busy cycles", 32'(cnt), 18);
    check("R2 busy low", 32'(bsy), 0);
  endtask

  task automatic t_fields();
    logic [7:0] s;
    look(0, 7, s); check("R4 int7", 32'(s), {1'b1, 1'b1, 1'b0, 5'd9});
    look(1, 7, s); check("R3 fp7 off", 32'(s), 0);
    wr(4, mk(1, 1, 12, 0, 1, 30)); wait_idle();
    look(1, 12, s); check("R3 fp12", 32'(s), {1'b1, 1'b0, 1'b1, 5'd30});
    look(0, 12, s); check("R3 int12 off", 32'(s), 0);
    look(0, 5, s); check("R9 unconfigured", 32'(s), 0);
  endtask

  task automatic t_invalid();
    logic [7:0] s;
    wr(5, mk(0, 0, 0, 1, 1, 17)); wait_idle();
    look(0, 0, s); check("R5 int0", 32'(s), 0);
  endtask

  task automatic t_priority();
    logic [7:0] s;
    wr(9, mk(1, 0, 20, 0, 1, 4));
    wr(2, mk(1, 0, 20, 1, 0, 11)); wait_idle();
    look(0, 20, s); check("R6 higher wins", 32'(s), {1'b1, 1'b0, 1'b1, 5'd4});
  endtask

  task automatic t_clear();
    logic [7:0] s;
    wr(9, mk(1, 0, 21, 0, 0, 2)); wait_idle();
    look(0, 21, s); check("R7 new reg", 32'(s), {1'b1, 1'b0, 1'b0, 5'd2});
    look(0, 20, s); check("R7 old from e2", 32'(s), {1'b1, 1'b1, 1'b0, 5'd11});
    wr(2, mk(0, 0, 20, 1, 0, 11)); wait_idle();
    look(0, 20, s); check("R7 cleared", 32'(s), 0);
  endtask

  task automatic t_shadow();
    logic [7:0] s;
    wr(3, mk(1, 0, 7, 0, 1, 1));
    repeat (5) @(negedge clk);
    look(0, 7, s); check("R8 old mid-pass", 32'(s), {1'b1, 1'b1, 1'b0, 5'd9});
    while (bsy) begin
      look(0, 7, s);
      if (s != {1'b1, 1'b1, 1'b0, 5'd9}) check("R8 old while busy", 32'(s), {1'b1, 1'b1, 1'b0, 5'd9});
      @(negedge clk);
    end
    look(0, 7, s); check("R8 new after", 32'(s), {1'b1, 1'b0, 1'b1, 5'd1});
  endtask

  task automatic t_restart();
    logic [7:0] s;
    int cnt = 0;
    wr(6, mk(1, 1, 1, 0, 0, 6));
    repeat (6) @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 4'd7; wdata = mk(1, 1, 2, 1, 1, 8);
    @(negedge clk); we = 1'b0;
    while (bsy && cnt < 100) begin cnt++; @(negedge clk); end
    check("R10 busy from last write", 32'(cnt), 18);
    look(1, 1, s); check("R10 first write", 32'(s), {1'b1, 1'b0, 1'b0, 5'd6});
    look(1, 2, s); check("R10 second write", 32'(s), {1'b1, 1'b1, 1'b1, 5'd8});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_len();
        t_fields();
        t_invalid();
        t_priority();
        t_clear();
        t_shadow();
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule